// File: doc/BRIEF.md
# Blinking Warning Sign Sequencer

A small clocked state machine that walks a five-lamp warning sign through a build-up pattern. The lamps are wired in three groups: the first pair, the second pair and the single last lamp. While the enable switch is on, the sign steps through four phases and then repeats. The phases are dark, first pair lit, both pairs lit, and every lamp lit. When the switch is released, the sign goes dark at the next clock edge.

The phase is held in a two-bit register that uses edge-triggered flip-flops. The phase code counts how many groups are lit: 0 means dark and 3 means all groups lit. Each lamp-group output is decoded from the phase register alone. The switch input therefore never reaches the lamps except through the register.

A step-enable input lets a fast system clock drive the sequencer at a slower stepping rate. When the step-enable input is low, the phase holds, but a released switch still clears the phase. A parameter can remove the step-enable input, so that the sign steps on every clock.

Top module: `warn_sign_seq`

## Requirements
- R1: A clock edge with `rst` high sets the phase to 0, and all three lamp-group outputs are then low.
- R2: With `switch_on` high and `step_en` high, each clock edge raises the phase by one, from 0 to 1, from 1 to 2 and from 2 to 3.
- R3: The outputs decode the phase as follows. Phase 0 drives all outputs low. Phase 1 drives only `grp_a` high. Phase 2 drives `grp_a` and `grp_b` high. Phase 3 drives all three outputs high.
- R4: A clock edge with `switch_on` low sets the phase to 0, whatever the value of `step_en`.
- R5: With `switch_on` high and `step_en` low, a clock edge leaves the phase unchanged. This applies when `USE_STEP_EN` is 1.
- R6: A change on `switch_on` or `step_en` between clock edges leaves the outputs unchanged until the next edge.
- R7: The lit groups always build up in order: `grp_c` high implies `grp_b` high, and `grp_b` high implies `grp_a` high.
- R8: From phase 3, with `switch_on` and `step_en` high, the next edge returns the phase to 0, and the pattern repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| switch_on | input | 1 | Sign enable switch |
| step_en | input | 1 | Step-enable tick; has no effect when `USE_STEP_EN` is 0 |
| grp_a | output | 1 | Drive for lamps 1 and 2 |
| grp_b | output | 1 | Drive for lamps 3 and 4 |
| grp_c | output | 1 | Drive for lamp 5 |

## Verification
Every effect of an input shows up after exactly one clock edge. The phase register takes the new value at that edge, and the outputs follow it through decode logic only. The bench therefore drives its inputs at the falling edge, lets one rising edge pass, and compares the outputs at the next falling edge against a phase model it computes itself. For R6, the bench changes an input in the middle of the low half of the cycle and samples the outputs a little later, before any edge can act on that change.

// File: rtl/sign_pkg.sv
package sign_pkg;
   // number of independently driven lamp groups
   localparam int GROUPS  = 3;
   // phases: dark plus one per lit group
   localparam int PHASES  = GROUPS + 1;
   localparam int PHASE_W = $clog2(PHASES);
   typedef logic [PHASE_W-1:0] phase_t;
   localparam phase_t PHASE_DARK = '0;
   localparam phase_t PHASE_FULL = phase_t'(GROUPS);
endpackage

// File: rtl/sign_step_gate.sv
module sign_step_gate #(
   parameter bit USE_STEP_EN = 1'b1
) (
   input  logic step_en,
   output logic advance
);
   generate
      if (USE_STEP_EN) begin : g_gated
         assign advance = step_en;
      end else begin : g_free
         logic unused_en;
         assign unused_en = step_en;
         assign advance   = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/sign_phase_reg.sv
module sign_phase_reg
   import sign_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   switch_on,
   input  logic   advance,
   output phase_t phase
);
   phase_t phase_nx;

   always_comb begin
      if (!switch_on) begin
         phase_nx = PHASE_DARK;
      end else if (advance) begin
         phase_nx = (phase == PHASE_FULL) ? PHASE_DARK : phase + phase_t'(1);
      end else begin
         phase_nx = phase;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) phase <= PHASE_DARK;
      else     phase <= phase_nx;
   end
endmodule

// File: rtl/sign_lamp_decode.sv
module sign_lamp_decode
   import sign_pkg::*;
(
   input  phase_t            phase,
   output logic [GROUPS-1:0] lit
);
   // group g is lit once the phase has passed it
   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign lit[g] = (phase > phase_t'(g));
   end
endmodule

// File: rtl/warn_sign_seq.sv
module warn_sign_seq
   import sign_pkg::*;
#(
   parameter bit USE_STEP_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic switch_on,
   input  logic step_en,
   output logic grp_a,
   output logic grp_b,
   output logic grp_c
);
   if (GROUPS != 3) begin : g_bad_groups
      $error("warn_sign_seq: the port list needs exactly three lamp groups");
   end
   if ((1 << PHASE_W) < PHASES) begin : g_bad_width
      $error("warn_sign_seq: phase register too narrow");
   end

   logic              advance;
   phase_t            phase;
   logic [GROUPS-1:0] lit;

   sign_step_gate #(.USE_STEP_EN(USE_STEP_EN)) u_gate (
      .step_en (step_en),
      .advance (advance)
   );

   sign_phase_reg u_phase (
      .clk       (clk),
      .rst       (rst),
      .switch_on (switch_on),
      .advance   (advance),
      .phase     (phase)
   );

   sign_lamp_decode u_dec (
      .phase (phase),
      .lit   (lit)
   );

   assign grp_a = lit[0];
   assign grp_b = lit[1];
   assign grp_c = lit[2];
endmodule

// File: rtl/warn_sign_seq_chk.sv
module warn_sign_seq_chk #(
   parameter bit USE_STEP_EN = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic switch_on,
   input logic step_en,
   input logic grp_a,
   input logic grp_b,
   input logic grp_c
);
   logic [1:0] lvl;
   assign lvl = 2'(grp_a) + 2'(grp_b) + 2'(grp_c);

   // R4: a released switch darkens the sign at the next edge
   a_r4_switch_off_dark: assert property (@(posedge clk) disable iff (rst)
      !switch_on |=> (lvl == 2'd0));

   // R2: one step per enabled edge below the top phase
   a_r2_one_step: assert property (@(posedge clk) disable iff (rst)
      (switch_on && (step_en || !USE_STEP_EN) && lvl != 2'd3)
      |=> (lvl == $past(lvl) + 2'd1));

   // R8: top phase wraps to dark
   a_r8_wrap_dark: assert property (@(posedge clk) disable iff (rst)
      (switch_on && (step_en || !USE_STEP_EN) && lvl == 2'd3) |=> (lvl == 2'd0));

   // R7: build-up order
   a_r7_c_needs_b: assert property (@(posedge clk) disable iff (rst)
      grp_c |-> grp_b);
   a_r7_b_needs_a: assert property (@(posedge clk) disable iff (rst)
      grp_b |-> grp_a);

   if (USE_STEP_EN) begin : g_hold
      // R5: no tick means no step
      a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
         (switch_on && !step_en) |=> $stable(lvl));
   end
endmodule

bind warn_sign_seq warn_sign_seq_chk #(.USE_STEP_EN(USE_STEP_EN)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .switch_on (switch_on),
   .step_en   (step_en),
   .grp_a     (grp_a),
   .grp_b     (grp_b),
   .grp_c     (grp_c)
);

// File: tb/warn_sign_seq_test.sv
module warn_sign_seq_test;
   logic clk = 1'b0;
   logic rst, switch_on, step_en;
   logic grp_a, grp_b, grp_c;
   int   total = 0;
   int   bad   = 0;
   int   model = 0;
   bit   done  = 1'b0;

   always #4 clk = ~clk;

   warn_sign_seq uut (
      .clk(clk), .rst(rst), .switch_on(switch_on), .step_en(step_en),
      .grp_a(grp_a), .grp_b(grp_b), .grp_c(grp_c)
   );

   task automatic check(input string req);
      logic [2:0] exp, got;
      exp = {model == 3, model >= 2, model >= 1};
      got = {grp_c, grp_b, grp_a};
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s phase=%0d got=%b exp=%b", req, model, got, exp);
      end
   endtask

   // drive at falling edge, one rising edge, compare at next falling edge
   task automatic cyc(input logic sw, input logic tk, input string req);
      switch_on = sw;
      step_en   = tk;
      @(posedge clk);
      if (rst)      model = 0;
      else if (!sw) model = 0;
      else if (tk)  model = (model + 1) % 4;
      @(negedge clk);
      check(req);
   endtask

   initial begin
      rst = 1'b1; switch_on = 1'b1; step_en = 1'b1;
      @(negedge clk);
      cyc(1'b1, 1'b1, "R1");
      cyc(1'b1, 1'b1, "R1");
      rst = 1'b0;
      // R2 R3 R8: two full rounds, every phase decoded
      for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, (model == 3) ? "R8" : "R2_R3");
      // R5: hold in each phase
      for (int p = 0; p < 4; p++) begin
         cyc(1'b1, 1'b0, "R5");
         cyc(1'b1, 1'b0, "R5");
         cyc(1'b1, 1'b1, "R2");
      end
      // R4: release from every phase, with and without tick
      for (int p = 0; p < 4; p++) begin
         for (int t = 0; t < 2; t++) begin
            for (int k = 0; k < p; k++) cyc(1'b1, 1'b1, "R2");
            cyc(1'b0, logic'(t), "R4");
         end
      end
      // R6: input change between edges leaves outputs alone
      cyc(1'b1, 1'b1, "R2");
      cyc(1'b1, 1'b1, "R2");
      #1 switch_on = 1'b0; step_en = 1'b0;
      #1 check("R6");
      @(posedge clk); model = 0;
      @(negedge clk); check("R4");
      // R1: reset from a lit phase
      cyc(1'b1, 1'b1, "R2");
      cyc(1'b1, 1'b1, "R2");
      rst = 1'b1;
      cyc(1'b1, 1'b1, "R1");
      rst = 1'b0;
      // R7 R3: sweep all input pairs from a stepping pattern
      for (int i = 0; i < 64; i++)
         cyc(logic'((i % 7) != 6), logic'((i % 3) != 1), "R7_R3");
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule